// File: doc/BRIEF.md
# Byte-Serial CRC-16 Engine

This block keeps a 16-bit record check over a stream of bytes, taking one byte on every clock where the byte strobe is high. Each accepted byte is folded into the upper half of the check register, after which the register is stepped right eight times against the reflected polynomial. All eight steps are unrolled, so a new byte can be accepted on every cycle.

A record starts with a clear. To generate a check, the record's bytes are fed in and the two check byte outputs are appended to the record, upper byte first. To verify a record, the data bytes are fed in, followed by the two check bytes as they were received. A remainder other than zero means the record is corrupt. A registered zero flag reports the state of the remainder and is aligned with the remainder output. Storing the record and deciding when to look at the flag are left to the surrounding logic.

Top module: `crc16_byte_engine`

## Requirements
- R1: Following reset, the remainder output is 0x0000 and the zero flag is 1.
- R2: An accepted byte B changes the register C to the result of eight steps applied to C XOR (B shifted left by 8). Each step shifts right by one. When bit 0 was 1 before the shift, the step then XORs the value with 0xA001. The new value appears on the remainder output after the clock edge that accepts the byte.
- R3: Clear asserted without the byte strobe makes the remainder 0x0000 after that edge.
- R4: Clear and the byte strobe asserted in the same cycle process the byte against a zero register, so a new record can begin with no idle cycle.
- R5: When neither clear nor the byte strobe is high, the remainder holds its value and the input byte has no effect.
- R6: The first check byte output equals remainder bits 15:8 and the second equals bits 7:0, in the order they are appended.
- R7: The zero flag is registered and is 1 exactly when the remainder output is 0x0000. It changes on the same edge as the remainder.
- R8: Feeding a record and then two received check bytes leaves the zero flag at 0 when the remainder is not zero, for example after any data byte is altered. It leaves the flag at 1 when the two bytes bring the remainder to zero.
- R9: Bytes presented on consecutive cycles are each absorbed, one per clock, with no cycles lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Start a new record (register seed to zero) |
| byte_vld_i | input | 1 | Byte strobe, one byte accepted per high cycle |
| byte_i | input | 8 | Input byte |
| crc_o | output | 16 | Current remainder |
| chk_first_o | output | 8 | Check byte appended first (upper half) |
| chk_second_o | output | 8 | Check byte appended second (lower half) |
| zero_o | output | 1 | Registered flag, remainder equals zero |

## Verification
The hardest case to reach from the ports is a verify pass that ends with a zero remainder. The check bytes appended by generate mode do not in general zero this register, so a pair that does has to be found. For each record, the bench searches all 256 values of the first received check byte. It looks for one that leaves the low half of the model register at zero, and takes the high half as the second byte. Feeding that pair must raise the zero flag. The same record with one data byte altered must leave the flag low. A sweep of all 256 single-byte records, each started with clear and strobe in the same cycle, covers the step logic exhaustively.

// File: rtl/crc16_byte_engine.sv
module crc16_byte_engine #(
  parameter int CRC_W = 16,
  parameter int DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'hA001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic [DATA_W-1:0] chk_first_o,
  output logic [DATA_W-1:0] chk_second_o,
  output logic              zero_o
);
  localparam int LOW_W = CRC_W - DATA_W;

  logic [CRC_W-1:0] crc_q, seed, nxt;
  logic [CRC_W-1:0] stage [0:DATA_W];
  logic             zero_q;

  assign seed     = clr_i ? '0 : crc_q;
  assign stage[0] = seed ^ {byte_i, {LOW_W{1'b0}}};

  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY) : (stage[i] >> 1);
  end

  assign nxt = byte_vld_i ? stage[DATA_W] : seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '0;
      zero_q <= 1'b1;
    end else begin
      crc_q  <= nxt;
      zero_q <= (nxt == '0);
    end
  end

  assign crc_o        = crc_q;
  assign chk_first_o  = crc_q[CRC_W-1 -: DATA_W];
  assign chk_second_o = crc_q[DATA_W-1:0];
  assign zero_o       = zero_q;
endmodule

module crc16_byte_engine_chk #(
  parameter int CRC_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              byte_vld_i,
  input logic [DATA_W-1:0] byte_i,
  input logic [CRC_W-1:0]  crc_o,
  input logic              zero_o
);
  assert_clear_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && !byte_vld_i |=> crc_o == '0 && zero_o);

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i && !byte_vld_i |=> $stable(crc_o) && $stable(zero_o));

  assert_zero_flag_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o == (crc_o == '0));

  assert_zero_byte_from_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && byte_vld_i && byte_i == '0 |=> crc_o == '0);

  assert_nonzero_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i && byte_vld_i && byte_i != '0 |=> crc_o != '0);
endmodule

bind crc16_byte_engine crc16_byte_engine_chk #(.CRC_W(CRC_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .byte_vld_i(byte_vld_i),
  .byte_i(byte_i), .crc_o(crc_o), .zero_o(zero_o)
);

// File: tb/crc16_byte_engine_tb.sv
`timescale 1ns/1ps
module crc16_byte_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic [15:0] crc_o;
  logic [7:0]  chk_first_o, chk_second_o;
  logic        zero_o;
  int checks = 0;
  int errors = 0;
  logic [15:0] model = 16'h0;

  always #10 clk = ~clk;

  crc16_byte_engine u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .crc_o(crc_o), .chk_first_o(chk_first_o),
    .chk_second_o(chk_second_o), .zero_o(zero_o)
  );

  function automatic logic [15:0] step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic beat(input logic c, input logic v, input logic [7:0] b);
    @(negedge clk);
    clr_i = c; byte_vld_i = v; byte_i = b;
    if (c) model = 16'h0;
    if (v) model = step(model, b);
    @(posedge clk);
    #1;
    clr_i = 1'b0; byte_vld_i = 1'b0;
  endtask

  task automatic check_state(input string req);
    check(req, {16'h0, crc_o}, {16'h0, model});
    check(req, {31'h0, zero_o}, {31'h0, model == 16'h0});
  endtask

  initial begin
    #5_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rec [0:5];
    logic [15:0] saved, probe;
    logic found;
    logic [7:0] x, y;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {16'h0, crc_o}, 32'h0);
    check("R1", {31'h0, zero_o}, 32'h1);
    @(negedge clk); rst_n = 1'b1;

    // R2 R4: exhaustive single-byte records started with clear and strobe together
    for (int b = 0; b < 256; b++) begin
      beat(1'b1, 1'b1, b[7:0]);
      check_state("R4");
    end

    // R9 R2: back-to-back record, then R6 check byte order
    beat(1'b1, 1'b0, 8'h00);
    check_state("R3");
    for (int i = 0; i < 6; i++) rec[i] = 8'h31 + 8'(i * 37);
    for (int i = 0; i < 6; i++) begin
      beat(1'b0, 1'b1, rec[i]);
      check_state("R9");
    end
    check("R6", {24'h0, chk_first_o}, {24'h0, model[15:8]});
    check("R6", {24'h0, chk_second_o}, {24'h0, model[7:0]});

    // R5: idle cycles with changing byte input leave remainder untouched
    saved = model;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); byte_i = 8'(8'hA5 ^ i);
      @(posedge clk); #1;
      check("R5", {16'h0, crc_o}, {16'h0, saved});
    end

    // R3: clear without strobe
    beat(1'b1, 1'b0, 8'hFF);
    check("R3", {16'h0, crc_o}, 32'h0);
    check("R7", {31'h0, zero_o}, 32'h1);

    // R8: several records verified with a found zeroing pair and with corruption
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 6; i++) rec[i] = 8'(r * 59 + i * 23 + 7);
      beat(1'b1, 1'b0, 8'h00);
      for (int i = 0; i < 6; i++) beat(1'b0, 1'b1, rec[i]);
      saved = model;
      found = 1'b0; x = 8'h00; y = 8'h00;
      for (int t = 0; t < 256; t++) begin
        probe = step(saved, t[7:0]);
        if (!found && probe[7:0] == 8'h00) begin
          found = 1'b1; x = t[7:0]; y = probe[15:8];
        end
      end
      if (found) begin
        beat(1'b0, 1'b1, x);
        beat(1'b0, 1'b1, y);
        check("R8", {31'h0, zero_o}, 32'h1);
        check("R7", {16'h0, crc_o}, 32'h0);
        beat(1'b1, 1'b0, 8'h00);
        for (int i = 0; i < 6; i++) beat(1'b0, 1'b1, (i == r) ? (rec[i] ^ 8'h10) : rec[i]);
        beat(1'b0, 1'b1, x);
        beat(1'b0, 1'b1, y);
        check_state("R8");
        check("R8", {31'h0, zero_o}, {31'h0, model == 16'h0});
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule